// File: doc/BRIEF.md
# Tagged Job and Result Queues

This block sits between a hashing chip's command decoder and its hash engines. It manages the work for one chip. Job frames carry a job tag in the top nibble of the command word. A job frame addressed to this chip is queued in a two-slot waiting queue. From there it is handed to the engine side as the running job, with its data words, midstate and target. The block owns the nonce counter of the running job. The counter starts at the 32-bit start value in the job payload and advances once per engine step. The search does not stop on a match: it goes on until the counter wraps from all ones to zero, and then the next waiting job is taken.

Each engine step that reports a match stores the job tag and the tried nonce in a five-entry result queue. A read request that is still unanswered and is addressed to this chip, or to everyone, takes the oldest result. The block then rewrites the response word so that the job tag sits in its top nibble and the chip's own address sits in its low byte, and returns the nonce with it. Frames already answered further up the chain, frames for other chips, and reads that find nothing pass through unchanged. Two clear inputs, driven from the queue-reset fields of the configuration register, discard the job side and the result side.

Top module: `hq_work_queues`

## Requirements
- R1: A job write is accepted only if all of these hold: command bits [11:8] are 4'h7, the tag in bits [15:12] is between 1 and 4, bits [7:0] equal `chip_addr`, and a waiting slot is free. `job_wr_ok` is 1 in the cycle after an accepted write and 0 after any refused one.
- R2: The waiting queue has two slots and is first in, first out. A job written while both slots hold jobs is refused, and the running order of the queued jobs does not change.
- R3: When no job is running and a job is waiting, that job starts one cycle later. `eng_run` goes to 1, and `eng_job_id`, `eng_data` (payload [447:320]), `eng_midstate` ([319:64]), `eng_target` ([63:32]) and `eng_nonce` (start value, [31:0]) show it.
- R4: Each cycle with `eng_step` high while running, `eng_nonce` increases by one. A step taken at nonce 32'hFFFFFFFF ends the job, and `eng_run` is 0 in the next cycle.
- R5: A step with `eng_hit` high stores {job tag, tried nonce} in the result queue, and the search carries on after the match.
- R6: The result queue holds five entries in first-in, first-out order. A match that finds it full is dropped and sets the sticky flag `res_ovf`. A match that arrives in the same cycle as a read that removes an entry is kept.
- R7: A read request with bits [15:12] = 0, bits [11:8] = 4'h8 and bits [7:0] equal to 0 or `chip_addr`, made while results are pending, removes the oldest result. One cycle later `rsp_cmd` = {tag, 4'h8, chip_addr} and `rsp_nonce` = its nonce.
- R8: Any other read request gives `rsp_cmd` = `rd_cmd` and `rsp_nonce` = `rd_nonce_in` one cycle later and removes nothing. This covers a non-zero top nibble, a different address, and an empty queue.
- R9: `clr_jobs` discards the running job and both waiting jobs, so `eng_run` is 0 in the next cycle. A job write in the same cycle is refused.
- R10: `clr_results` empties the result queue and clears `res_ovf`. It wins over a match and a read made in the same cycle, and that read is answered as in R8.
- R11: After reset, `eng_run`, `job_wr_ok`, `rsp_valid` and `res_ovf` are 0, and a read finds no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_addr | input | 8 | This chip's chain address |
| job_wr_valid | input | 1 | Job frame present |
| job_wr_cmd | input | 16 | Job command word |
| job_wr_payload | input | 448 | Data, midstate, target, start nonce (MSB first) |
| job_wr_ok | output | 1 | Previous cycle's job write accepted |
| eng_run | output | 1 | A job is running |
| eng_job_id | output | 4 | Tag of the running job |
| eng_data | output | 128 | Data words of the running job |
| eng_midstate | output | 256 | Midstate of the running job |
| eng_target | output | 32 | Target of the running job |
| eng_nonce | output | 32 | Nonce to try next |
| eng_step | input | 1 | Engine tried `eng_nonce` this cycle |
| eng_hit | input | 1 | The tried nonce meets the target |
| rd_req | input | 1 | Read frame present |
| rd_cmd | input | 16 | Incoming read command word |
| rd_nonce_in | input | 32 | Incoming nonce word (from upstream) |
| rsp_valid | output | 1 | Response for previous cycle's read |
| rsp_cmd | output | 16 | Outgoing command word |
| rsp_nonce | output | 32 | Outgoing nonce word |
| clr_jobs | input | 1 | Discard running and waiting jobs |
| clr_results | input | 1 | Discard results and overflow flag |
| res_ovf | output | 1 | Sticky: a match was dropped |

## Verification
Storing a match and removing a result by a read can fall in the same cycle, and that matters most when the result queue is full. The bench fills all five entries, then issues a matching step together with a broadcast read. The response must carry the oldest entry, `res_ovf` must stay 0, and the five reads that follow must return the other four entries plus the new match, in order. A second collision puts a queue clear on the same cycle as a match and a read. It is judged by a pass-through response and an empty queue on the next read.

// File: rtl/hq_pkg.sv
package hq_pkg;
  localparam int ID_W    = 4;
  localparam int NONCE_W = 32;
  localparam int MAX_ID  = 4;

  localparam logic [3:0] OP_JOB  = 4'h7;
  localparam logic [3:0] OP_READ = 4'h8;

  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic [NONCE_W-1:0] nonce;
  } result_t;
endpackage

// File: rtl/hq_fifo.sv
module hq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         push_ok
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, rd_ptr_nx, wr_ptr_nx;
  logic [CW-1:0] count, count_nx;
  logic          do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_pop    = pop && (count != '0) && !clr;
    push_ok   = push && !clr && ((count != CW'(DEPTH)) || do_pop);
    rd_ptr_nx = rd_ptr;
    wr_ptr_nx = wr_ptr;
    count_nx  = count;
    if (clr) begin
      rd_ptr_nx = '0;
      wr_ptr_nx = '0;
      count_nx  = '0;
    end else begin
      if (do_pop)  rd_ptr_nx = ptr_inc(rd_ptr);
      if (push_ok) wr_ptr_nx = ptr_inc(wr_ptr);
      if (push_ok && !do_pop)      count_nx = count + 1'b1;
      else if (do_pop && !push_ok) count_nx = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_nx;
      wr_ptr <= wr_ptr_nx;
      count  <= count_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
endmodule

// File: rtl/hq_runner.sv
module hq_runner
  import hq_pkg::*;
#(
  parameter int PAY_W = 448
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               job_avail,
  input  logic [ID_W-1:0]    job_id_in,
  input  logic [PAY_W-1:0]   job_pay_in,
  input  logic               step,
  input  logic               hit,
  output logic               job_take,
  output logic               run,
  output logic [ID_W-1:0]    cur_id,
  output logic [PAY_W-1:0]   cur_pay,
  output logic [NONCE_W-1:0] nonce,
  output logic               hit_push,
  output result_t            hit_res
);
  logic               run_nx, last_step;
  logic [NONCE_W-1:0] nonce_nx;

  always_comb begin
    job_take  = !run && job_avail && !clr;
    last_step = run && step && (nonce == '1);
    hit_push  = run && step && hit;
    hit_res   = '{id: cur_id, nonce: nonce};

    run_nx = run;
    if (clr)            run_nx = 1'b0;
    else if (job_take)  run_nx = 1'b1;
    else if (last_step) run_nx = 1'b0;

    nonce_nx = nonce;
    if (job_take)         nonce_nx = job_pay_in[NONCE_W-1:0];
    else if (run && step) nonce_nx = nonce + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      nonce  <= '0;
      cur_id <= '0;
    end else begin
      run   <= run_nx;
      nonce <= nonce_nx;
      if (job_take) cur_id <= job_id_in;
    end
  end

  always_ff @(posedge clk) begin
    if (job_take) cur_pay <= job_pay_in;
  end
endmodule

// File: rtl/hq_reader.sv
module hq_reader
  import hq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [7:0]         chip_addr,
  input  logic               rd_req,
  input  logic [15:0]        rd_cmd,
  input  logic [NONCE_W-1:0] rd_nonce_in,
  input  logic               res_avail,
  input  result_t            res_head,
  output logic               res_take,
  output logic               rsp_valid,
  output logic [15:0]        rsp_cmd,
  output logic [NONCE_W-1:0] rsp_nonce
);
  logic               for_us;
  logic [15:0]        cmd_nx;
  logic [NONCE_W-1:0] nonce_nx;

  always_comb begin
    for_us = rd_req && (rd_cmd[15:12] == 4'h0) && (rd_cmd[11:8] == OP_READ) &&
             ((rd_cmd[7:0] == 8'h00) || (rd_cmd[7:0] == chip_addr));
    res_take = for_us && res_avail && !clr;
    if (res_take) begin
      cmd_nx   = {res_head.id, OP_READ, chip_addr};
      nonce_nx = res_head.nonce;
    end else begin
      cmd_nx   = rd_cmd;
      nonce_nx = rd_nonce_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_cmd   <= '0;
      rsp_nonce <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) begin
        rsp_cmd   <= cmd_nx;
        rsp_nonce <= nonce_nx;
      end
    end
  end
endmodule

// File: rtl/hq_work_queues.sv
module hq_work_queues
  import hq_pkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int MID_W     = 256,
  parameter int TGT_W     = 32,
  parameter int JOB_SLOTS = 2,
  parameter int RES_SLOTS = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [7:0]                       chip_addr,
  input  logic                             job_wr_valid,
  input  logic [15:0]                      job_wr_cmd,
  input  logic [DATA_W+MID_W+TGT_W+32-1:0] job_wr_payload,
  output logic                             job_wr_ok,
  output logic                             eng_run,
  output logic [3:0]                       eng_job_id,
  output logic [DATA_W-1:0]                eng_data,
  output logic [MID_W-1:0]                 eng_midstate,
  output logic [TGT_W-1:0]                 eng_target,
  output logic [31:0]                      eng_nonce,
  input  logic                             eng_step,
  input  logic                             eng_hit,
  input  logic                             rd_req,
  input  logic [15:0]                      rd_cmd,
  input  logic [31:0]                      rd_nonce_in,
  output logic                             rsp_valid,
  output logic [15:0]                      rsp_cmd,
  output logic [31:0]                      rsp_nonce,
  input  logic                             clr_jobs,
  input  logic                             clr_results,
  output logic                             res_ovf
);
  localparam int PAY_W  = DATA_W + MID_W + TGT_W + NONCE_W;
  localparam int JOB_W  = ID_W + PAY_W;
  localparam int RES_W  = $bits(result_t);
  localparam int TGT_LO = NONCE_W;
  localparam int MID_LO = TGT_LO + TGT_W;
  localparam int DAT_LO = MID_LO + MID_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // job admission
  logic [ID_W-1:0]  wr_id;
  logic             wr_legal, inq_push_ok, inq_empty, job_take;
  logic [JOB_W-1:0] inq_head;
  logic [PAY_W-1:0] cur_pay;

  always_comb begin
    wr_id    = job_wr_cmd[15:12];
    wr_legal = job_wr_valid && (job_wr_cmd[11:8] == OP_JOB) &&
               (wr_id != '0) && (wr_id <= ID_W'(MAX_ID)) &&
               (job_wr_cmd[7:0] == chip_addr);
  end

  hq_fifo #(.W(JOB_W), .DEPTH(JOB_SLOTS)) u_jobq (
    .clk(clk), .rst_n(rst_q_n), .clr(clr_jobs),
    .push(wr_legal), .pop(job_take), .din({wr_id, job_wr_payload}),
    .dout(inq_head), .empty(inq_empty), .push_ok(inq_push_ok)
  );

  logic    hit_push;
  result_t hit_res;

  hq_runner #(.PAY_W(PAY_W)) u_run (
    .clk(clk), .rst_n(rst_q_n), .clr(clr_jobs),
    .job_avail(!inq_empty), .job_id_in(inq_head[JOB_W-1 -: ID_W]),
    .job_pay_in(inq_head[PAY_W-1:0]), .step(eng_step), .hit(eng_hit),
    .job_take(job_take), .run(eng_run), .cur_id(eng_job_id),
    .cur_pay(cur_pay), .nonce(eng_nonce), .hit_push(hit_push), .hit_res(hit_res)
  );

  assign eng_data     = cur_pay[DAT_LO +: DATA_W];
  assign eng_midstate = cur_pay[MID_LO +: MID_W];
  assign eng_target   = cur_pay[TGT_LO +: TGT_W];

  // result side
  logic             res_push_ok, res_empty, res_take;
  logic [RES_W-1:0] res_head_raw;

  hq_fifo #(.W(RES_W), .DEPTH(RES_SLOTS)) u_resq (
    .clk(clk), .rst_n(rst_q_n), .clr(clr_results),
    .push(hit_push), .pop(res_take), .din(hit_res),
    .dout(res_head_raw), .empty(res_empty), .push_ok(res_push_ok)
  );

  hq_reader u_rd (
    .clk(clk), .rst_n(rst_q_n), .clr(clr_results), .chip_addr(chip_addr),
    .rd_req(rd_req), .rd_cmd(rd_cmd), .rd_nonce_in(rd_nonce_in),
    .res_avail(!res_empty), .res_head(result_t'(res_head_raw)),
    .res_take(res_take), .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_nonce(rsp_nonce)
  );

  logic ovf_nx, ok_nx;
  always_comb begin
    ovf_nx = res_ovf;
    if (clr_results)                   ovf_nx = 1'b0;
    else if (hit_push && !res_push_ok) ovf_nx = 1'b1;
    ok_nx = inq_push_ok;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_ovf   <= 1'b0;
      job_wr_ok <= 1'b0;
    end else begin
      res_ovf   <= ovf_nx;
      job_wr_ok <= ok_nx;
    end
  end
endmodule

// File: rtl/hq_work_queues_chk.sv
module hq_work_queues_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  chip_addr,
  input logic        job_wr_valid,
  input logic [15:0] job_wr_cmd,
  input logic        job_wr_ok,
  input logic        eng_run,
  input logic [31:0] eng_nonce,
  input logic        eng_step,
  input logic        rd_req,
  input logic [15:0] rd_cmd,
  input logic [31:0] rd_nonce_in,
  input logic        rsp_valid,
  input logic [15:0] rsp_cmd,
  input logic [31:0] rsp_nonce,
  input logic        clr_jobs,
  input logic        clr_results,
  input logic        res_ovf
);
  AST_JOB_BAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    job_wr_valid && (job_wr_cmd[15:12] == 4'h0 || job_wr_cmd[15:12] > 4'h4) |=> !job_wr_ok); // R1
  AST_JOB_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    job_wr_valid && (job_wr_cmd[7:0] != chip_addr) |=> !job_wr_ok); // R1
  AST_NONCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_run && eng_step && !clr_jobs && (eng_nonce != 32'hFFFF_FFFF)
    |=> eng_run && (eng_nonce == $past(eng_nonce) + 32'd1)); // R4
  AST_WRAP_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_run && eng_step && (eng_nonce == 32'hFFFF_FFFF) |=> !eng_run); // R4
  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R7
  AST_RSP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && (rd_cmd[15:12] == 4'h0) && (rd_cmd[11:8] == 4'h8)
    |=> (rsp_cmd[11:8] == 4'h8) &&
        ((rsp_cmd[7:0] == $past(rd_cmd[7:0])) || (rsp_cmd[7:0] == $past(chip_addr)))); // R7
  AST_PASS_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && (rd_cmd[15:12] != 4'h0)
    |=> (rsp_cmd == $past(rd_cmd)) && (rsp_nonce == $past(rd_nonce_in))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovf && !clr_results |=> res_ovf); // R6
  AST_CLR_JOBS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_jobs |=> !eng_run && !job_wr_ok); // R9
  AST_CLR_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_results |=> !res_ovf); // R10
  AST_CLR_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_results && rd_req |=> (rsp_cmd == $past(rd_cmd)) && (rsp_nonce == $past(rd_nonce_in))); // R10
endmodule

bind hq_work_queues hq_work_queues_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_addr(chip_addr),
  .job_wr_valid(job_wr_valid), .job_wr_cmd(job_wr_cmd), .job_wr_ok(job_wr_ok),
  .eng_run(eng_run), .eng_nonce(eng_nonce), .eng_step(eng_step),
  .rd_req(rd_req), .rd_cmd(rd_cmd), .rd_nonce_in(rd_nonce_in),
  .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_nonce(rsp_nonce),
  .clr_jobs(clr_jobs), .clr_results(clr_results), .res_ovf(res_ovf)
);

// File: tb/hq_work_queues_bench.sv
module hq_work_queues_bench;
  localparam logic [7:0] CHIP = 8'h03;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         job_wr_valid, eng_step, eng_hit, rd_req, clr_jobs, clr_results;
  logic [15:0]  job_wr_cmd, rd_cmd, rsp_cmd;
  logic [447:0] job_wr_payload;
  logic         job_wr_ok, eng_run, rsp_valid, res_ovf;
  logic [3:0]   eng_job_id;
  logic [127:0] eng_data;
  logic [255:0] eng_midstate;
  logic [31:0]  eng_target, eng_nonce, rd_nonce_in, rsp_nonce;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hq_work_queues u_hq_work_queues (
    .clk(clk), .rst_n(rst_n), .chip_addr(CHIP),
    .job_wr_valid(job_wr_valid), .job_wr_cmd(job_wr_cmd), .job_wr_payload(job_wr_payload),
    .job_wr_ok(job_wr_ok), .eng_run(eng_run), .eng_job_id(eng_job_id),
    .eng_data(eng_data), .eng_midstate(eng_midstate), .eng_target(eng_target),
    .eng_nonce(eng_nonce), .eng_step(eng_step), .eng_hit(eng_hit),
    .rd_req(rd_req), .rd_cmd(rd_cmd), .rd_nonce_in(rd_nonce_in),
    .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_nonce(rsp_nonce),
    .clr_jobs(clr_jobs), .clr_results(clr_results), .res_ovf(res_ovf)
  );

  function automatic logic [447:0] mk_pay(input logic [3:0] id, input logic [31:0] base);
    return {{4{32'hD000_0000 + 32'(id)}}, {8{32'hC000_0000 + 32'(id)}},
            32'h0000_FF00 + 32'(id), base};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_job(input logic [15:0] cmd, input logic [31:0] base, input bit clrj,
                           input logic exp_ok, input string req);
    job_wr_valid = 1'b1; job_wr_cmd = cmd; job_wr_payload = mk_pay(cmd[15:12], base);
    clr_jobs = clrj;
    tick();
    job_wr_valid = 1'b0; clr_jobs = 1'b0;
    chk(req, 64'(job_wr_ok), 64'(exp_ok));
  endtask

  task automatic step(input logic hit);
    eng_step = 1'b1; eng_hit = hit;
    tick();
    eng_step = 1'b0; eng_hit = 1'b0;
  endtask

  task automatic read(input logic [15:0] cmd, input logic [31:0] nin,
                      input logic [15:0] ecmd, input logic [31:0] enon, input string req);
    rd_req = 1'b1; rd_cmd = cmd; rd_nonce_in = nin;
    tick();
    rd_req = 1'b0;
    chk(req, {15'd0, rsp_valid, rsp_cmd, rsp_nonce}, {15'd0, 1'b1, ecmd, enon});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; job_wr_valid = 1'b0; job_wr_cmd = '0; job_wr_payload = '0;
    eng_step = 1'b0; eng_hit = 1'b0; rd_req = 1'b0; rd_cmd = '0; rd_nonce_in = '0;
    clr_jobs = 1'b0; clr_results = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R11 reset state
    chk("R11 idle outputs", {60'd0, eng_run, job_wr_ok, rsp_valid, res_ovf}, 64'd0);
    read(16'h0800, 32'h0, 16'h0800, 32'h0, "R11 R8 empty read");

    // R1 refusals
    write_job(16'h2707, 32'hFFFF_FFF0, 1'b0, 1'b0, "R1 other address");
    write_job(16'h0703, 32'hFFFF_FFF0, 1'b0, 1'b0, "R1 tag zero");
    write_job(16'h5703, 32'hFFFF_FFF0, 1'b0, 1'b0, "R1 tag five");
    write_job(16'h2903, 32'hFFFF_FFF0, 1'b0, 1'b0, "R1 not a job op");
    chk("R1 nothing started", 64'(eng_run), 64'd0);

    // R1 R3 first job starts one cycle after its write
    write_job(16'h2703, 32'hFFFF_FFF0, 1'b0, 1'b1, "R1 valid write");
    chk("R3 not yet running", 64'(eng_run), 64'd0);
    tick();
    chk("R3 run and tag", {59'd0, eng_run, eng_job_id}, {59'd0, 1'b1, 4'd2});
    chk("R3 start nonce", 64'(eng_nonce), 64'hFFFF_FFF0);
    chk("R3 target", 64'(eng_target), 64'h0000_FF02);
    chk("R3 data", 64'(eng_data[127:64]), {2{32'hD000_0002}});
    chk("R3 midstate", 64'(eng_midstate[255:192]), {2{32'hC000_0002}});

    // R2 two waiting slots, third refused
    write_job(16'h3703, 32'hFFFF_FFFC, 1'b0, 1'b1, "R2 slot one");
    write_job(16'h1703, 32'hFFFF_FFFE, 1'b0, 1'b1, "R2 slot two");
    write_job(16'h4703, 32'h0000_0000, 1'b0, 1'b0, "R2 full refused");

    // R4 R5 job 2: sixteen steps, matches at F2, F5, FF
    for (int i = 0; i < 16; i++) begin
      step(i == 2 || i == 5 || i == 15);
      if (i < 15) chk("R4 nonce advance", 64'(eng_nonce), 64'(32'hFFFF_FFF0 + 32'(i + 1)));
      else        chk("R4 retire on wrap", 64'(eng_run), 64'd0);
    end
    tick();
    chk("R2 second job in order", {59'd0, eng_run, eng_job_id}, {59'd0, 1'b1, 4'd3});
    chk("R3 second start nonce", 64'(eng_nonce), 64'hFFFF_FFFC);

    // R6 job 3: matches FC, FD, FE -> FE is the sixth and is dropped
    for (int i = 0; i < 4; i++) begin
      chk("R6 overflow flag timing", 64'(res_ovf), 64'(i >= 3));
      step(i < 3);
    end
    chk("R6 overflow sticky", 64'(res_ovf), 64'd1);
    chk("R4 job 3 retired", 64'(eng_run), 64'd0);
    tick();
    chk("R2 third job in order", {59'd0, eng_run, eng_job_id}, {59'd0, 1'b1, 4'd1});
    step(1'b0); step(1'b0);
    tick(); tick();
    chk("R2 refused job never runs", 64'(eng_run), 64'd0);

    // R7 R8 R5 reads in order
    read(16'h0800, 32'h0, {4'd2, 4'h8, CHIP}, 32'hFFFF_FFF2, "R7 broadcast read");
    read(16'h0803, 32'h0, {4'd2, 4'h8, CHIP}, 32'hFFFF_FFF5, "R7 addressed read");
    read(16'h0807, 32'hDEAD_0001, 16'h0807, 32'hDEAD_0001, "R8 other chip");
    read(16'h1805, 32'h1234_5678, 16'h1805, 32'h1234_5678, "R8 already answered");
    read(16'h0800, 32'h0, {4'd2, 4'h8, CHIP}, 32'hFFFF_FFFF, "R5 match after match");
    read(16'h0800, 32'h0, {4'd3, 4'h8, CHIP}, 32'hFFFF_FFFC, "R7 job 3 first");
    read(16'h0800, 32'h0, {4'd3, 4'h8, CHIP}, 32'hFFFF_FFFD, "R6 fifth entry");
    read(16'h0800, 32'h0000_0042, 16'h0800, 32'h0000_0042, "R6 R8 dropped entry absent");
    chk("R6 flag held", 64'(res_ovf), 64'd1);

    clr_results = 1'b1; tick(); clr_results = 1'b0;
    chk("R10 flag cleared", 64'(res_ovf), 64'd0);

    // R6 full queue: a match and a read in the same cycle
    write_job(16'h4703, 32'hFFFF_FFFA, 1'b0, 1'b1, "R1 job 4 write");
    tick();
    chk("R3 job 4 running", {59'd0, eng_run, eng_job_id}, {59'd0, 1'b1, 4'd4});
    for (int i = 0; i < 5; i++) step(1'b1);
    eng_step = 1'b1; eng_hit = 1'b1;
    read(16'h0800, 32'h0, {4'd4, 4'h8, CHIP}, 32'hFFFF_FFFA, "R6 push and pop together");
    eng_step = 1'b0; eng_hit = 1'b0;
    chk("R6 no overflow on collision", 64'(res_ovf), 64'd0);
    for (int i = 1; i < 6; i++)
      read(16'h0800, 32'h0, {4'd4, 4'h8, CHIP}, 32'hFFFF_FFFA + 32'(i), "R6 fifo order");
    read(16'h0800, 32'h0, 16'h0800, 32'h0, "R8 drained");

    // R10 clear wins over a match and a read in the same cycle
    write_job(16'h3703, 32'h0000_0100, 1'b0, 1'b1, "R1 job write");
    tick();
    step(1'b1);
    eng_step = 1'b1; eng_hit = 1'b1; clr_results = 1'b1;
    read(16'h0800, 32'h0000_0007, 16'h0800, 32'h0000_0007, "R10 read during clear");
    eng_step = 1'b0; eng_hit = 1'b0; clr_results = 1'b0;
    read(16'h0800, 32'h0, 16'h0800, 32'h0, "R10 queue empty after clear");
    chk("R10 job untouched", {31'd0, eng_run, eng_nonce}, {31'd0, 1'b1, 32'h0000_0102});

    // R9 job clear wins over a write, discards waiting job
    write_job(16'h1703, 32'h0, 1'b0, 1'b1, "R1 waiting job");
    write_job(16'h2703, 32'h0, 1'b1, 1'b0, "R9 write during clear");
    chk("R9 running job gone", 64'(eng_run), 64'd0);
    tick(); tick();
    chk("R9 waiting job gone", 64'(eng_run), 64'd0);
    write_job(16'h2703, 32'h0000_0055, 1'b0, 1'b1, "R9 queue usable after clear");
    tick();
    chk("R9 new job starts", {27'd0, eng_run, eng_job_id, eng_nonce},
        {27'd0, 1'b1, 4'd2, 32'h0000_0055});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule